// File: doc/BRIEF.md
# Sixteen-bit Capture Timer

This block is a 16-bit down-counter with a reload latch. Software reaches it through an 8-bit register port that has a low byte and a high byte. A count-source select picks one of several count-enable lines. Each pulse on the selected line lowers the count by one. The pulse that finds the count at zero reloads it from the latch and raises a one-cycle underflow interrupt request. A 16-bit value goes in as two byte writes, low byte first. Only the high-byte write commits the value, and it commits it to both the latch and the counter.

In period measurement mode, an external capture pin is brought into the clock domain through a synchronizer chain. The active edge of the pin, rising or falling, is chosen by an edge-select input. Each active edge reloads the counter from the latch and raises a one-cycle capture interrupt request. When no capture is currently held, the edge also stores the count it interrupted. That stored value is kept until software has read the timer once. Reads take the high byte first, which snapshots the low byte into a shadow register, and then the low byte, which returns the shadow. In timer mode a read returns the live count. In period mode a read returns the captured value.

Top module: `capture_timer16`

## Requirements
- R1: After a synchronous active-low reset, the counter, latch, captured value and read shadow are zero and both interrupt outputs are low.
- R2: A write strobe on `wr_lo` only stages `wdata`; the readable count does not change. A `wr_hi` strobe loads {`wdata`, staged low byte} into both latch and counter at that clock edge.
- R3: Each clock with `src_ticks[src_sel]` high lowers the count by one; the other `src_ticks` lines have no effect.
- R4: A selected tick while the count is 0x0000 reloads it from the latch and drives `irq_unf` high for the following cycle, giving a division ratio of 1/(n+1) for latch value n.
- R5: A read with `rd_hi` returns bits 15:8 on `rdata` in that same cycle and snapshots bits 7:0. The next read with `rd_lo` returns that snapshot, even if the count has moved in between.
- R6: With `mode_sel` = 0 (timer mode), reads return the live count.
- R7: With `mode_sel` = 1 (period mode), an active capture edge reloads the counter from the latch and drives `irq_cap` high for exactly one cycle.
- R8: `edge_fall` = 0 makes a low-to-high transition of `cap_pin` active; `edge_fall` = 1 makes a high-to-low transition active; the opposite transition raises no request and leaves the count alone.
- R9: In period mode, reads return the count captured at an accepted edge. A low-byte read releases it. While it is held, further edges still reload and interrupt but do not overwrite it.
- R10: A `cap_pin` change applied between two clock edges produces `irq_cap` high after the third following rising clock edge, through the two-stage synchronizer and the edge register.
- R11: In timer mode, `cap_pin` transitions raise no `irq_cap` and do not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ticks | input | NSRC (4) | Candidate count-enable lines |
| src_sel | input | $clog2(NSRC) (2) | Index of the count-enable line in use |
| mode_sel | input | 1 | 0 timer mode, 1 period measurement mode |
| edge_fall | input | 1 | 0 rising capture edge, 1 falling |
| cap_pin | input | 1 | Asynchronous capture input |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe (commits) |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe (snapshots low byte) |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid while a read strobe is high |
| irq_unf | output | 1 | One-cycle underflow interrupt request |
| irq_cap | output | 1 | One-cycle capture interrupt request |

## Verification
The bench reads a byte pair while the counter is stepping across a 0x0100 boundary. A design that reads the low byte live would return 0x01FF instead of 0x0100. It sends a second active edge while a capture is still held, and later checks that the count was reloaded. A design that overwrote the held value, or that skipped the reload, returns the wrong capture. A latch value of zero and a count of exactly n+1 ticks expose off-by-one underflow and reload errors. A single high-byte write after a lone low-byte write shows whether staging and commit are separate steps. It also checks that the opposite edge polarity and timer-mode edges leave the interrupts and the count untouched, and it times the capture request to the exact cycle the synchronizer depth implies.

// File: rtl/cap_timer_pkg.sv
// Package: shared definitions for the capture timer.
// Assumes: mode select is a single bit driven by a control register elsewhere.
package cap_timer_pkg;
    typedef enum logic {
        TMR_MODE_FREE   = 1'b0,
        TMR_MODE_PERIOD = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/cap_timer_sync.sv
// Module: cap_timer_sync
// Brings an asynchronous pin into the clock domain through STAGES flops and
// flags one cycle for each transition of the selected polarity.
// Assumes: STAGES >= 2; the pin is low when reset is released.
module cap_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic fall_sel,
    output logic edge_hit
);
    logic synced;
    logic prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic q;
        if (g == 0) begin : g_first
            // first stage: sample the raw pin
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= pin_async;
            end
        end else begin : g_next
            // later stages: shift the sample along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign synced = g_stage[STAGES-1].q;

    // keep last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    // choose rising or falling transition
    always_comb begin
        if (fall_sel) edge_hit = prev_q & ~synced;
        else          edge_hit = ~prev_q & synced;
    end
endmodule

// File: rtl/cap_timer_counter.sv
// Module: cap_timer_counter
// Down-counter with reload latch, staged low-byte write and underflow pulse.
// Assumes: WIDTH is even; a high-byte write takes priority over a capture
// reload, which takes priority over a count tick.
module cap_timer_counter #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [WIDTH/2-1:0] wdata,
    input  logic               cap_reload,
    output logic [WIDTH-1:0]   cnt_q,
    output logic [WIDTH-1:0]   latch_q,
    output logic               irq_unf
);
    localparam int BYTE_W = WIDTH / 2;
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [BYTE_W-1:0] stage_lo;
    logic [WIDTH-1:0]  commit_val;

    assign commit_val = {wdata, stage_lo};

    // hold the low byte until the high byte arrives
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_lo <= '0;
        else if (wr_lo) stage_lo <= wdata;
    end

    // reload latch: changes only on a committed write
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (wr_hi) latch_q <= commit_val;
    end

    // counter: commit, capture reload, or count with underflow reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            irq_unf <= 1'b0;
        end else begin
            irq_unf <= 1'b0;
            if (wr_hi) begin
                cnt_q <= commit_val;
            end else if (cap_reload) begin
                cnt_q <= latch_q;
            end else if (tick) begin
                if (cnt_q == '0) begin
                    cnt_q   <= latch_q;
                    irq_unf <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/cap_timer_capture.sv
// Module: cap_timer_capture
// Capture register with read-once hold, read source mux and low-byte shadow.
// Assumes: software reads high byte then low byte; rd_hi wins if both strobe.
module cap_timer_capture #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_period,
    input  logic               cap_ev,
    input  logic [WIDTH-1:0]   cnt_q,
    input  logic               rd_hi,
    input  logic               rd_lo,
    output logic [WIDTH/2-1:0] rdata,
    output logic               cap_take,
    output logic               held_q,
    output logic [WIDTH-1:0]   cap_val_q,
    output logic               irq_cap
);
    localparam int BYTE_W = WIDTH / 2;

    logic [WIDTH-1:0]  src;
    logic [BYTE_W-1:0] shadow_q;

    assign cap_take = cap_ev & ~held_q;
    assign src      = mode_period ? cap_val_q : cnt_q;

    // capture value and its hold flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val_q <= '0;
            held_q    <= 1'b0;
        end else if (cap_take) begin
            cap_val_q <= cnt_q;
            held_q    <= 1'b1;
        end else if (rd_lo) begin
            held_q    <= 1'b0;
        end
    end

    // capture interrupt pulse, one cycle per accepted edge
    always_ff @(posedge clk) begin
        if (!rst_n) irq_cap <= 1'b0;
        else        irq_cap <= cap_ev;
    end

    // low-byte shadow taken on the high-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (rd_hi) shadow_q <= src[BYTE_W-1:0];
    end

    // read data mux
    always_comb begin
        if (rd_hi)      rdata = src[WIDTH-1:BYTE_W];
        else if (rd_lo) rdata = shadow_q;
        else            rdata = '0;
    end
endmodule

// File: rtl/capture_timer16.sv
// Module: capture_timer16 (top)
// 16-bit reloadable down-timer with byte register port and period capture.
// Assumes: strobes are single-cycle requests from a register decoder;
// cap_pin is asynchronous; src_ticks are clock-enables in this domain.
module capture_timer16
    import cap_timer_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int NSRC        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         src_ticks,
    input  logic [$clog2(NSRC)-1:0] src_sel,
    input  logic                    mode_sel,
    input  logic                    edge_fall,
    input  logic                    cap_pin,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic                    rd_lo,
    input  logic                    rd_hi,
    input  logic [WIDTH/2-1:0]      wdata,
    output logic [WIDTH/2-1:0]      rdata,
    output logic                    irq_unf,
    output logic                    irq_cap
);
    logic             tick;
    logic             mode_period;
    logic             edge_hit;
    logic             cap_ev;
    logic             cap_take;
    logic             held_q;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] cap_val_q;

    assign tick        = src_ticks[src_sel];
    assign mode_period = (tmr_mode_e'(mode_sel) == TMR_MODE_PERIOD);
    assign cap_ev      = edge_hit & mode_period;

    cap_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin),
        .fall_sel  (edge_fall),
        .edge_hit  (edge_hit)
    );

    cap_timer_counter #(.WIDTH(WIDTH)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (wdata),
        .cap_reload (cap_ev),
        .cnt_q      (cnt_q),
        .latch_q    (latch_q),
        .irq_unf    (irq_unf)
    );

    cap_timer_capture #(.WIDTH(WIDTH)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_period (mode_period),
        .cap_ev      (cap_ev),
        .cnt_q       (cnt_q),
        .rd_hi       (rd_hi),
        .rd_lo       (rd_lo),
        .rdata       (rdata),
        .cap_take    (cap_take),
        .held_q      (held_q),
        .cap_val_q   (cap_val_q),
        .irq_cap     (irq_cap)
    );
endmodule

// File: rtl/capture_timer16_chk.sv
// Module: capture_timer16_chk
// Temporal checks on the capture timer, attached to the top by bind.
// Assumes: synchronous active-low reset disables every property.
module capture_timer16_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_hi,
    input logic             rd_lo,
    input logic             mode_period,
    input logic             cap_ev,
    input logic             cap_take,
    input logic             held_q,
    input logic [WIDTH-1:0] cnt_q,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] cap_val_q,
    input logic             irq_unf,
    input logic             irq_cap
);
    assert_commit_loads_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cnt_q == latch_q));

    assert_tick_decrements_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_hi && !cap_ev && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_underflow_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_unf |-> (cnt_q == latch_q));

    assert_capture_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap |-> (cnt_q == latch_q));

    assert_held_value_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        held_q |=> $stable(cap_val_q));

    assert_low_read_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !cap_take) |=> !held_q);

    assert_timer_mode_no_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_period |=> !irq_cap);
endmodule

bind capture_timer16 capture_timer16_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .wr_hi       (wr_hi),
    .rd_lo       (rd_lo),
    .mode_period (mode_period),
    .cap_ev      (cap_ev),
    .cap_take    (cap_take),
    .held_q      (held_q),
    .cnt_q       (cnt_q),
    .latch_q     (latch_q),
    .cap_val_q   (cap_val_q),
    .irq_unf     (irq_unf),
    .irq_cap     (irq_cap)
);

// File: tb/test_capture_timer16.sv
`timescale 1ns/1ps
// Bench: vector table for timer-mode division, then directed capture,
// ordering, polarity and reset tests.
module test_capture_timer16;
    localparam int NSRC = 4;

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] load;
        logic [15:0] n;
        logic [15:0] cnt;
        logic [7:0]  unf;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 16'h0005, 16'd3,   16'h0002, 8'd0},
        '{2'd1, 16'h0003, 16'd4,   16'h0003, 8'd1},
        '{2'd2, 16'h0002, 16'd7,   16'h0001, 8'd2},
        '{2'd3, 16'h0000, 16'd5,   16'h0000, 8'd5},
        '{2'd0, 16'hABCD, 16'd1,   16'hABCC, 8'd0},
        '{2'd1, 16'h0100, 16'd257, 16'h0100, 8'd1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_ticks = '0;
    logic [1:0]      src_sel = '0;
    logic            mode_sel = 1'b0;
    logic            edge_fall = 1'b0;
    logic            cap_pin = 1'b0;
    logic            wr_lo = 1'b0, wr_hi = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            irq_unf, irq_cap;

    int checks = 0;
    int errors = 0;
    int unf_seen = 0;
    int cap_seen = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    capture_timer16 i_capture_timer16 (
        .clk(clk), .rst_n(rst_n), .src_ticks(src_ticks), .src_sel(src_sel),
        .mode_sel(mode_sel), .edge_fall(edge_fall), .cap_pin(cap_pin),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .wdata(wdata), .rdata(rdata), .irq_unf(irq_unf), .irq_cap(irq_cap)
    );

    always @(negedge clk) begin
        if (irq_unf) unf_seen++;
        if (irq_cap) cap_seen++;
    end

    function automatic logic [NSRC-1:0] idle_lines(input logic [1:0] s);
        return ~(4'b0001 << s);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] v);
        @(negedge clk); wr_lo = 1'b1; wdata = v[7:0];
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = v[15:8];
        @(negedge clk); wr_hi = 1'b0;
    endtask

    task automatic do_read(output logic [15:0] v);
        @(negedge clk); rd_hi = 1'b1; #1 v[15:8] = rdata;
        @(negedge clk); rd_hi = 1'b0; rd_lo = 1'b1; #1 v[7:0] = rdata;
        @(negedge clk); rd_lo = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        if (n > 0) begin
            @(negedge clk); src_ticks = '1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk); src_ticks = idle_lines(src_sel);
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); cap_pin = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        src_ticks = idle_lines(2'd0);
        @(negedge clk);
        check("R1 irq_unf after reset", irq_unf, 0);
        check("R1 irq_cap after reset", irq_cap, 0);
        do_read(rv);
        check("R1 count after reset", rv, 16'h0000);
        mode_sel = 1'b1;
        do_read(rv);
        check("R1 capture after reset", rv, 16'h0000);
        mode_sel = 1'b0;

        // table: timer-mode division and underflow (R3 R4 R6)
        foreach (VECS[i]) begin
            @(negedge clk);
            src_sel = VECS[i].sel;
            src_ticks = idle_lines(VECS[i].sel);
            do_write(VECS[i].load);
            unf_seen = 0;
            do_ticks(int'(VECS[i].n));
            repeat (2) @(negedge clk);
            do_read(rv);
            check($sformatf("R3 R6 count vec %0d", i), rv, VECS[i].cnt);
            check($sformatf("R4 underflows vec %0d", i), unf_seen, VECS[i].unf);
        end

        // R2: low byte alone stages, high byte commits
        src_sel = 2'd0; src_ticks = idle_lines(2'd0);
        do_write(16'h1234);
        @(negedge clk); wr_lo = 1'b1; wdata = 8'h99;
        @(negedge clk); wr_lo = 1'b0;
        do_read(rv);
        check("R2 low write alone", rv, 16'h1234);
        @(negedge clk); wr_hi = 1'b1; wdata = 8'h56;
        @(negedge clk); wr_hi = 1'b0;
        do_read(rv);
        check("R2 high write commits", rv, 16'h5699);
        unf_seen = 0;
        do_write(16'h0001);
        do_ticks(2);
        do_write(16'h0100);
        do_read(rv);
        check("R4 latch reload after write", unf_seen, 1);

        // R5: coherent pair while counting across 0x0100
        @(negedge clk); rd_hi = 1'b1; src_ticks = '1; #1 rv[15:8] = rdata;
        @(negedge clk); rd_hi = 1'b0; rd_lo = 1'b1; src_ticks = idle_lines(2'd0); #1 rv[7:0] = rdata;
        @(negedge clk); rd_lo = 1'b0;
        check("R5 snapshot pair", rv, 16'h0100);
        do_read(rv);
        check("R5 R6 live count moved", rv, 16'h00FF);

        // R7 R10: first capture, rising edge
        mode_sel = 1'b1; edge_fall = 1'b0;
        do_write(16'h0050);
        do_ticks(16);
        cap_seen = 0;
        @(negedge clk); cap_pin = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 no request before third edge", irq_cap, 0);
        @(negedge clk);
        check("R7 R10 request after third edge", irq_cap, 1);
        @(negedge clk);
        check("R7 request lasts one cycle", irq_cap, 0);
        do_read(rv);
        check("R9 captured count", rv, 16'h0040);
        mode_sel = 1'b0;
        do_read(rv);
        check("R7 counter reloaded", rv, 16'h0050);
        mode_sel = 1'b1;

        // R8 R9: polarity and hold
        do_ticks(5);
        cap_seen = 0;
        set_pin(1'b0);
        check("R8 falling ignored in rising mode", cap_seen, 0);
        set_pin(1'b1);
        do_ticks(3);
        set_pin(1'b0);
        set_pin(1'b1);
        check("R9 edge while held still interrupts", cap_seen, 2);
        do_read(rv);
        check("R8 R9 held value kept", rv, 16'h004B);
        do_ticks(2);
        set_pin(1'b0);
        set_pin(1'b1);
        do_read(rv);
        check("R9 release and reload on held edge", rv, 16'h004E);

        // R8: falling polarity
        edge_fall = 1'b1;
        do_write(16'h0030);
        do_ticks(4);
        cap_seen = 0;
        set_pin(1'b0);
        check("R8 falling edge accepted", cap_seen, 1);
        do_read(rv);
        check("R8 falling capture value", rv, 16'h002C);
        set_pin(1'b1);
        check("R8 rising ignored in falling mode", cap_seen, 1);

        // R11: timer mode ignores the pin
        mode_sel = 1'b0;
        do_write(16'h0077);
        cap_seen = 0;
        set_pin(1'b0);
        set_pin(1'b1);
        check("R11 no capture request", cap_seen, 0);
        do_read(rv);
        check("R11 count untouched", rv, 16'h0077);

        // R1: reset in mid-run
        do_write(16'h1234);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(rv);
        check("R1 count after mid-run reset", rv, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule